// File: doc/BRIEF.md
# Logarithmic-depth prefix adder

This block adds two unsigned WIDTH-bit operands and a carry-in without any clock. Each column first forms a generate bit (both operand bits set) and a propagate bit (either operand bit set). The carry-in is handled as one more column that sits below bit 0. That column generates exactly when the carry-in is set and never propagates. A tree of merge cells then combines neighbouring spans. The spans double in width at each level, so after log2(WIDTH) levels every column holds the group generate that reaches down to the carry-in column. That group generate is the carry into the column.

Each sum bit is the exclusive OR of the two operand bits and the carry into that column. The carry-out comes from merging the generate and propagate of the top column with the prefix just below it. WIDTH is a power of two, at least 2. The block sits inside a larger datapath as a plain combinational function, so it has no handshake and no state.

Top module: `pfx_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, all three taken as unsigned.
- R2: `cout_o` equals bit WIDTH of that same full-width total.
- R3: When no bit position has both `a_i` and `b_i` set and `cin_i` is 0, `sum_o` equals `a_i ^ b_i` and `cout_o` is 0.
- R4: With `a_i` all ones, `b_i` zero and `cin_i` 1, the carry-in crosses every column: `sum_o` is zero and `cout_o` is 1.
- R5: With `a_i` all ones, `b_i` zero and `cin_i` 0, `sum_o` is all ones and `cout_o` is 0.
- R6: With `a_i` all ones, `b_i` equal to 1 and `cin_i` 0, a carry made in column 0 reaches the top: `sum_o` is zero and `cout_o` is 1.
- R7: The outputs depend only on the present inputs. They settle within the same clock period in which the inputs change, and no earlier input affects them.
- R8: The adder built with WIDTH set to 4 satisfies R1 and R2 for all 512 combinations of its inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into column 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of the top column |

## Verification
A 4-bit copy is driven through every operand and carry-in combination. This exposes any wrong span pairing in a tree that is small enough to reach every path. The 16-bit copy gets random operand pairs with random carry-in, which catch errors in the merge cells at every level. It also gets random pairs with no shared set bits, which must produce no carry anywhere and so separate generate faults from propagate faults. Fixed patterns force the longest carry paths: an all-ones operand with the carry-in set, the same operand plus one, and the same operand with nothing added. These show whether the column below bit 0 and the top merge into the carry-out are wired correctly.

// File: rtl/pfx_adder_pkg.sv
package pfx_adder_pkg;

  // Position of the top of the lower half when a position merges at a level.
  // Positions are numbered so that position 0 is the carry-in column and
  // position k+1 is operand column k.
  function automatic int lower_top(input int pos, input int lvl);
    return ((pos >> lvl) << lvl) - 1;
  endfunction

  // True when the position lies in the upper half of its span at a level.
  function automatic bit merges_at(input int pos, input int lvl);
    return ((pos >> lvl) & 1) == 1;
  endfunction

endpackage

// File: rtl/pfx_colgen.sv
module pfx_colgen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] leaf_g_o,
  output logic [WIDTH-1:0] leaf_p_o,
  output logic             top_g_o,
  output logic             top_p_o,
  output logic [WIDTH-1:0] half_o
);

  // Position 0 is the carry-in column: it generates with cin, never propagates.
  assign leaf_g_o[0] = cin_i;
  assign leaf_p_o[0] = 1'b0;

  for (genvar c = 0; c < WIDTH - 1; c++) begin : g_col
    assign leaf_g_o[c+1] = a_i[c] & b_i[c];
    assign leaf_p_o[c+1] = a_i[c] | b_i[c];
  end

  // The top column only feeds the carry-out merge.
  assign top_g_o = a_i[WIDTH-1] & b_i[WIDTH-1];
  assign top_p_o = a_i[WIDTH-1] | b_i[WIDTH-1];

  assign half_o = a_i ^ b_i;

endmodule

// File: rtl/pfx_cell.sv
module pfx_cell (
  input  logic hi_g_i,
  input  logic hi_p_i,
  input  logic lo_g_i,
  input  logic lo_p_i,
  output logic g_o,
  output logic p_o
);

  assign g_o = hi_g_i | (hi_p_i & lo_g_i);
  assign p_o = hi_p_i & lo_p_i;

endmodule

// File: rtl/pfx_gcell.sv
module pfx_gcell (
  input  logic hi_g_i,
  input  logic hi_p_i,
  input  logic lo_g_i,
  output logic g_o
);

  assign g_o = hi_g_i | (hi_p_i & lo_g_i);

endmodule

// File: rtl/pfx_tree.sv
module pfx_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] leaf_g_i,
  input  logic [WIDTH-1:0] leaf_p_i,
  output logic [WIDTH-1:0] carry_o
);
  import pfx_adder_pkg::*;

  localparam int LEVELS = $clog2(WIDTH);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    logic [WIDTH-1:0] prev_g;
    logic [WIDTH-1:0] prev_p;
    logic [WIDTH-1:0] cur_g;

    if (l == 0) begin : g_src_leaf
      assign prev_g = leaf_g_i;
      assign prev_p = leaf_p_i;
    end else begin : g_src_stage
      assign prev_g = g_lvl[l-1].cur_g;
      assign prev_p = g_lvl[l-1].cur_p;
    end

    if (l < LEVELS - 1) begin : g_full
      logic [WIDTH-1:0] cur_p_w;
      for (genvar p = 0; p < WIDTH; p++) begin : g_pos
        if (merges_at(p, l)) begin : g_merge
          pfx_cell u_cell (
            .hi_g_i(prev_g[p]),
            .hi_p_i(prev_p[p]),
            .lo_g_i(prev_g[lower_top(p, l)]),
            .lo_p_i(prev_p[lower_top(p, l)]),
            .g_o   (cur_g[p]),
            .p_o   (cur_p_w[p])
          );
        end else begin : g_pass
          assign cur_g[p]   = prev_g[p];
          assign cur_p_w[p] = prev_p[p];
        end
      end
    end else begin : g_last
      // Final level: only generate is consumed downstream.
      for (genvar p = 0; p < WIDTH; p++) begin : g_pos
        if (merges_at(p, l)) begin : g_merge
          pfx_gcell u_gcell (
            .hi_g_i(prev_g[p]),
            .hi_p_i(prev_p[p]),
            .lo_g_i(prev_g[lower_top(p, l)]),
            .g_o   (cur_g[p])
          );
        end else begin : g_pass
          assign cur_g[p] = prev_g[p];
        end
      end
    end

    logic [WIDTH-1:0] cur_p;
    if (l < LEVELS - 1) begin : g_pout
      assign cur_p = g_full.cur_p_w;
    end else begin : g_pnone
      assign cur_p = prev_p;
    end
  end

  // Prefix generate at position p is the carry into operand column p.
  assign carry_o = g_lvl[LEVELS-1].cur_g;

endmodule

// File: rtl/pfx_sum.sv
module pfx_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] half_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             top_g_i,
  input  logic             top_p_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  assign sum_o = half_i ^ carry_i;

  pfx_gcell u_cout (
    .hi_g_i(top_g_i),
    .hi_p_i(top_p_i),
    .lo_g_i(carry_i[WIDTH-1]),
    .g_o   (cout_o)
  );

endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] leaf_g;
  logic [WIDTH-1:0] leaf_p;
  logic [WIDTH-1:0] half;
  logic [WIDTH-1:0] carry;
  logic             top_g;
  logic             top_p;

  pfx_colgen #(.WIDTH(WIDTH)) u_colgen (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .leaf_g_o(leaf_g),
    .leaf_p_o(leaf_p),
    .top_g_o (top_g),
    .top_p_o (top_p),
    .half_o  (half)
  );

  pfx_tree #(.WIDTH(WIDTH)) u_tree (
    .leaf_g_i(leaf_g),
    .leaf_p_i(leaf_p),
    .carry_o (carry)
  );

  pfx_sum #(.WIDTH(WIDTH)) u_sum (
    .half_i (half),
    .carry_i(carry),
    .top_g_i(top_g),
    .top_p_i(top_p),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);

  logic [WIDTH:0] total;
  assign total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    assert_sum_R1: assert (sum_o == total[WIDTH-1:0])
      else $error("sum mismatch");
    assert_cout_R2: assert (cout_o == total[WIDTH])
      else $error("carry-out mismatch");
    if (((a_i & b_i) == '0) && !cin_i) begin
      assert_nogen_R3: assert ((sum_o == (a_i ^ b_i)) && !cout_o)
        else $error("carry appeared without any generate");
    end
    if ((&a_i) && (b_i == '0) && cin_i) begin
      assert_cin_path_R4: assert ((sum_o == '0) && cout_o)
        else $error("carry-in did not cross all columns");
    end
    if ((&a_i) && (b_i == '0) && !cin_i) begin
      assert_hold_R5: assert ((sum_o == a_i) && !cout_o)
        else $error("all-ones operand altered without carry");
    end
  end

endmodule

bind pfx_adder pfx_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o)
);

// File: tb/sim_pfx_adder.sv
module sim_pfx_adder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [3:0]  a4, b4, s4;
  logic        c4, co4;

  pfx_adder #(.WIDTH(16)) u0 (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
  );

  pfx_adder #(.WIDTH(4)) u1 (
    .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4)
  );

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R7 watchdog: actual cycles=%0d expected below 20000", cycles);
      report();
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer addition, sampled half a cycle after drive.
  task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input string tag);
    longint total;
    @(posedge clk);
    a16 = a; b16 = b; c16 = c;
    @(negedge clk);
    total = longint'(a) + longint'(b) + longint'(c);
    check({tag, " R1 sum"}, longint'(s16), total & 64'hFFFF);
    check({tag, " R2 cout"}, longint'(co16), (total >> 16) & 1);
  endtask

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a4 = '0; b4 = '0; c4 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset-state R1 sum", longint'(s16), 0);
    check("reset-state R2 cout", longint'(co16), 0);

    // R4: carry-in travels through every column
    run16(16'hFFFF, 16'h0000, 1'b1, "R4");
    check("R4 zero sum", longint'(s16), 0);
    check("R4 cout set", longint'(co16), 1);

    // R5: all ones with nothing added
    run16(16'hFFFF, 16'h0000, 1'b0, "R5");
    check("R5 unchanged", longint'(s16), 64'hFFFF);
    check("R5 no cout", longint'(co16), 0);

    // R6: carry made at column 0 reaches the top
    run16(16'hFFFF, 16'h0001, 1'b0, "R6");
    check("R6 zero sum", longint'(s16), 0);
    check("R6 cout set", longint'(co16), 1);
    run16(16'h0001, 16'hFFFF, 1'b1, "R6 swapped");
    check("R6 swapped sum", longint'(s16), 1);

    // R3: disjoint operands, no carry-in
    for (int i = 0; i < 300; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom) & ~ra;
      run16(ra, rb, 1'b0, "R3");
      check("R3 xor sum", longint'(s16), longint'(ra ^ rb));
      check("R3 no cout", longint'(co16), 0);
    end

    // R1/R2/R7: random operands, random carry-in, each new pair every cycle
    for (int i = 0; i < 1500; i++) begin
      run16(16'($urandom), 16'($urandom), 1'($urandom), "R7 random");
    end

    // R8: exhaustive narrow instance
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int t;
          @(posedge clk);
          a4 = 4'(a); b4 = 4'(b); c4 = 1'(c);
          @(negedge clk);
          t = a + b + c;
          check("R8 sum", longint'(s4), longint'(t & 15));
          check("R8 cout", longint'(co4), longint'((t >> 4) & 1));
        end
      end
    end

    report();
    $finish;
  end

endmodule